// File: doc/BRIEF.md
# Machine Cycle State Sequencer

This block is the cycle-level control sequencer of a small 8-bit processor core. It decides, machine cycle by machine cycle, whether the core fetches an instruction, executes it, performs a DMA transfer or takes an interrupt. It reports the current cycle type on a two-bit state code and produces two timing pulses inside every cycle. The rest of the core uses these pulses to latch addresses and to complete bus transfers.

Each normal cycle spans eight clocks, counted by a phase counter. The cycle that follows reset spans nine clocks, because one extra clock comes before counting starts. The next cycle type is chosen at the cycle boundary. The inputs are the DMA and interrupt requests, sampled once per cycle, and two hints from the instruction decoder. One hint marks a long instruction that needs a second execute cycle. The other marks an idle instruction that parks the core in execute cycles. A hold input pauses the sequencer for as long as it stays high. The phase counter and every output keep their values during the pause, and counting resumes from the same phase.

The reset input is active low and acts asynchronously. Its release is synchronized through a two-stage chain before the sequencer starts counting.

Top module: `cycle_seq`

## Requirements
- R1: Every machine cycle other than the first one after reset lasts exactly 8 clocks. After rst_n rises, the first fetch cycle begins on the 11th rising clock edge: 2 edges for the reset release and 9 clocks of initialization.
- R2: state_code encodes the cycle type: 00 fetch, 01 execute, 10 DMA, 11 interrupt. While reset is active, and during initialization, state_code reads 01.
- R3: tpa is high for exactly one clock per cycle, during phase 1. tpb is high for one clock, during phase 6, so that tpb goes high 5 clocks after tpa does.
- R4: A fetch cycle is always followed by an execute cycle.
- R5: At the end of an execute, DMA or interrupt cycle, the next cycle is chosen in this order: a pending DMA request, then a pending enabled interrupt, then fetch.
- R6: When long_hint is high during the first execute cycle of an instruction, a second execute cycle follows before the R5 decision is made.
- R7: When idle_hint is high during an execute cycle, execute cycles repeat until a DMA or interrupt request is served. After that service the normal R5 order resumes.
- R8: A DMA cycle may be followed directly by another DMA cycle or by an interrupt cycle. An interrupt cycle may be followed by a DMA cycle.
- R9: While hold_req is high, the phase counter, state_code, tpa and tpb keep their values. Once hold_req goes low, counting resumes from the held phase.
- R10: irq_req is honoured only when irq_en is also high. irq_en_clr is high during phase 1 of each interrupt cycle.
- R11: Requests are sampled only at the end of phase 6. A DMA request that is dropped before then has no effect, and the next cycle is a fetch.
- R12: When both DMA requests are pending, the inbound one is served. dma_in_cyc is 1 during a DMA cycle that serves dma_in_req and 0 during every other cycle.
- R13: Asserting rst_n low during any cycle at once forces state_code to 01 and drives tpa and tpb low. Release is then followed by the full initialization sequence of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Pause request; freezes the sequencer while high |
| dma_in_req | input | 1 | Inbound DMA request |
| dma_out_req | input | 1 | Outbound DMA request |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| long_hint | input | 1 | Decoder hint: instruction needs two execute cycles |
| idle_hint | input | 1 | Decoder hint: idle instruction |
| state_code | output | 2 | Current cycle type |
| tpa | output | 1 | First timing pulse (phase 1) |
| tpb | output | 1 | Second timing pulse (phase 6) |
| dma_in_cyc | output | 1 | Current DMA cycle serves the inbound request |
| irq_en_clr | output | 1 | Strobe telling the core to clear irq_en |

## Verification
The embedded properties check the following on every cycle:
- the phase returns to zero after a boundary;
- the phase, state and pulses hold still under hold_req;
- tpa lasts a single clock;
- fetch is always followed by execute;
- a pending DMA request wins at the decision point;
- a long instruction gets its second execute cycle;
- no interrupt cycle starts without a sampled, enabled request.

Only the bench scenarios can show the remaining behaviour. They time the 9-clock initialization after reset release, both when power-up and mid-cycle resets are released. They also cover the chained DMA and interrupt sequences, the repeated execute cycles of an idle instruction, and the loss of a request that is dropped before the sampling phase. Finally they check the whole sequence around an indefinite pause.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_EXEC  = 2'b01,
    CYC_DMA   = 2'b10,
    CYC_INT   = 2'b11
  } cyc_t;

  // request snapshot taken once per machine cycle
  typedef struct packed {
    logic dma;
    logic dma_in;
    logic irq;
    logic lng;
    logic idle;
  } req_snap_t;

endpackage

// File: rtl/cseq_rst_sync.sv
`timescale 1ns/1ps
module cseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ni = chain_q[STAGES-1];

endmodule

// File: rtl/cseq_phase.sv
`timescale 1ns/1ps
module cseq_phase #(
  parameter int CYC_LEN = 8,
  parameter int TPA_PH  = 1,
  parameter int TPB_PH  = 6,
  parameter int SMP_PH  = 6,
  localparam int PH_W   = $clog2(CYC_LEN)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            adv,
  output logic [PH_W-1:0] phase,
  output logic            pre,
  output logic            tpa,
  output logic            tpb,
  output logic            smp_en,
  output logic            boundary
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);
  localparam logic [PH_W-1:0] A_PH    = PH_W'(TPA_PH);
  localparam logic [PH_W-1:0] B_PH    = PH_W'(TPB_PH);
  localparam logic [PH_W-1:0] S_PH    = PH_W'(SMP_PH);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            pre_q, pre_d;
  logic            count_en;

  // the extra initialization clock is spent in pre
  assign count_en = adv && !pre_q;

  always_comb begin
    pre_d   = pre_q && !adv;
    phase_d = phase_q;
    if (count_en) begin
      if (phase_q == LAST_PH) phase_d = '0;
      else                    phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pre_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      pre_q   <= pre_d;
    end
  end

  assign phase    = phase_q;
  assign pre      = pre_q;
  assign tpa      = !pre_q && (phase_q == A_PH);
  assign tpb      = !pre_q && (phase_q == B_PH);
  assign smp_en   = count_en && (phase_q == S_PH);
  assign boundary = count_en && (phase_q == LAST_PH);

  // R1: a boundary always wraps to phase 0
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    boundary |=> (phase == '0));

  // R9: no advance while paused
  p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !adv |=> $stable(phase) && $stable(pre));

endmodule

// File: rtl/cseq_sample.sv
`timescale 1ns/1ps
module cseq_sample
  import cseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      smp_en,
  input  logic      dma_in_req,
  input  logic      dma_out_req,
  input  logic      irq_req,
  input  logic      irq_en,
  input  logic      long_hint,
  input  logic      idle_hint,
  output req_snap_t snap
);

  req_snap_t snap_q, snap_d;

  always_comb begin
    snap_d = snap_q;
    if (smp_en) begin
      snap_d.dma    = dma_in_req || dma_out_req;
      snap_d.dma_in = dma_in_req;
      snap_d.irq    = irq_req && irq_en;
      snap_d.lng    = long_hint;
      snap_d.idle   = idle_hint;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else         snap_q <= snap_d;
  end

  assign snap = snap_q;

  // R11: the snapshot only moves at the sampling phase
  p_snap_stable_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !smp_en |=> $stable(snap));

endmodule

// File: rtl/cseq_ctrl.sv
`timescale 1ns/1ps
module cseq_ctrl
  import cseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      adv,
  input  logic      boundary,
  input  req_snap_t snap,
  output cyc_t      cur,
  output logic      init,
  output logic      dir_in
);

  cyc_t cur_q, cur_d;
  logic init_q, init_d;
  logic long2_q, long2_d;
  logic idle_q, idle_d;
  logic dir_q, dir_d;
  cyc_t serve;
  logic take_second;

  // request-driven choice shared by every decision point
  always_comb begin
    if (snap.dma)      serve = CYC_DMA;
    else if (snap.irq) serve = CYC_INT;
    else               serve = CYC_FETCH;
  end

  assign take_second = snap.lng && !long2_q && !idle_q;

  always_comb begin
    cur_d   = cur_q;
    init_d  = init_q;
    long2_d = long2_q;
    idle_d  = idle_q;
    dir_d   = dir_q;
    if (boundary) begin
      long2_d = 1'b0;
      unique case (cur_q)
        CYC_FETCH: cur_d = CYC_EXEC;
        CYC_EXEC: begin
          if (init_q) begin
            cur_d  = CYC_FETCH;
            init_d = 1'b0;
          end else if (take_second) begin
            cur_d   = CYC_EXEC;
            long2_d = 1'b1;
          end else if (serve != CYC_FETCH) begin
            cur_d  = serve;
            idle_d = 1'b0;
          end else if (idle_q || snap.idle) begin
            cur_d  = CYC_EXEC;
            idle_d = 1'b1;
          end else begin
            cur_d = CYC_FETCH;
          end
        end
        default: cur_d = serve;
      endcase
      dir_d = (cur_d == CYC_DMA) && snap.dma_in;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= CYC_EXEC;
      init_q  <= 1'b1;
      long2_q <= 1'b0;
      idle_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      cur_q   <= cur_d;
      init_q  <= init_d;
      long2_q <= long2_d;
      idle_q  <= idle_d;
      dir_q   <= dir_d;
    end
  end

  assign cur    = cur_q;
  assign init   = init_q;
  assign dir_in = dir_q;

  // R2: initialization reports as execute
  p_init_code_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    init |-> (cur == CYC_EXEC));

  // R4: execute after fetch
  p_fetch_exec_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    boundary && (cur == CYC_FETCH) |=> (cur == CYC_EXEC));

  // R5: DMA first at a decision point
  p_dma_first_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    boundary && snap.dma && !init && (cur != CYC_FETCH) &&
    !((cur == CYC_EXEC) && take_second) |=> (cur == CYC_DMA));

  // R6: long instruction gets its second execute
  p_long_two_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    boundary && (cur == CYC_EXEC) && !init && take_second |=> (cur == CYC_EXEC));

  // R10: no interrupt cycle without a sampled enabled request
  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    boundary && !snap.irq && (cur != CYC_INT) |=> (cur != CYC_INT));

  // R9: cycle type held while paused
  p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !adv |=> $stable(cur) && $stable(dir_in));

endmodule

// File: rtl/cycle_seq.sv
`timescale 1ns/1ps
module cycle_seq
  import cseq_pkg::*;
#(
  parameter int CYC_LEN     = 8,
  parameter int TPA_PH      = 1,
  parameter int TPB_PH      = 6,
  parameter int SMP_PH      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_req,
  input  logic       dma_in_req,
  input  logic       dma_out_req,
  input  logic       irq_req,
  input  logic       irq_en,
  input  logic       long_hint,
  input  logic       idle_hint,
  output logic [1:0] state_code,
  output logic       tpa,
  output logic       tpb,
  output logic       dma_in_cyc,
  output logic       irq_en_clr
);

  localparam int PH_W = $clog2(CYC_LEN);

  logic            rst_ni;
  logic            adv;
  logic [PH_W-1:0] phase;
  logic            pre;
  logic            smp_en;
  logic            boundary;
  req_snap_t       snap;
  cyc_t            cur;
  logic            init;
  logic            dir_in;

  assign adv = !hold_req;

  cseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  cseq_phase #(
    .CYC_LEN (CYC_LEN),
    .TPA_PH  (TPA_PH),
    .TPB_PH  (TPB_PH),
    .SMP_PH  (SMP_PH)
  ) u_phase (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .adv      (adv),
    .phase    (phase),
    .pre      (pre),
    .tpa      (tpa),
    .tpb      (tpb),
    .smp_en   (smp_en),
    .boundary (boundary)
  );

  cseq_sample u_sample (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .smp_en      (smp_en),
    .dma_in_req  (dma_in_req),
    .dma_out_req (dma_out_req),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .long_hint   (long_hint),
    .idle_hint   (idle_hint),
    .snap        (snap)
  );

  cseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .adv      (adv),
    .boundary (boundary),
    .snap     (snap),
    .cur      (cur),
    .init     (init),
    .dir_in   (dir_in)
  );

  assign state_code = cur;
  assign dma_in_cyc = (cur == CYC_DMA) && dir_in;
  assign irq_en_clr = (cur == CYC_INT) && tpa;

  // R3: tpa lasts one clock unless paused
  p_tpa_single_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    tpa && !hold_req |=> !tpa);

  // R9: outputs frozen under hold
  p_out_frozen_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_req |=> $stable(state_code) && $stable(tpa) && $stable(tpb));

  // R3: pulses never overlap, none during the extra init clock
  p_pulse_pre_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    pre |-> !tpa && !tpb && init);

endmodule

// File: tb/sim_cycle_seq.sv
`timescale 1ns/1ps
module sim_cycle_seq;

  logic       clk = 1'b0;
  logic       rst_n, hold, dmai, dmao, irq, ien, lng, idl;
  logic [1:0] code;
  logic       tpa, tpb, din, clr;
  int         errs = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  cycle_seq u0 (
    .clk (clk), .rst_n (rst_n), .hold_req (hold),
    .dma_in_req (dmai), .dma_out_req (dmao), .irq_req (irq), .irq_en (ien),
    .long_hint (lng), .idle_hint (idl),
    .state_code (code), .tpa (tpa), .tpb (tpb),
    .dma_in_cyc (din), .irq_en_clr (clr)
  );

  // {dmai,dmao,irq,ien,long, exp1[1:0], exp1_din, exp2[1:0]}
  localparam logic [9:0] VEC [9] = '{
    10'b00000_00_0_01,
    10'b10000_10_1_00,
    10'b01000_10_0_00,
    10'b00110_11_0_00,
    10'b00100_00_0_01,
    10'b10110_10_1_00,
    10'b00001_01_0_00,
    10'b01001_01_0_00,
    10'b11000_10_1_00
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    dmai = 0; dmao = 0; irq = 0; ien = 0; lng = 0; idl = 0;
  endtask

  task automatic next_tpa();
    @(negedge clk);
    while (!tpa) @(negedge clk);
  endtask

  task automatic to_fetch();
    next_tpa();
    while (code != 2'b00) next_tpa();
  endtask

  // called with rst_n low; releases it and times the init cycle
  task automatic release_and_time(input string tag);
    int n;
    int na;
    @(negedge clk);
    rst_n = 1;
    n = 0;
    na = 0;
    do begin
      @(negedge clk);
      n++;
      if (tpa) na++;
    end while (code != 2'b00 && n < 40);
    chk(n == 11, tag, n, 11);
    chk(na == 1, {tag, " init tpa"}, na, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    int m;
    bit ok;
    logic [1:0] c0;
    logic [9:0] v;
    rst_n = 0;
    hold = 0;
    clear_in();
    @(negedge clk);
    @(negedge clk);
    // R2 reset state
    chk(code == 2'b01, "R2 reset code", code, 1);
    chk(!tpa && !tpb && !din && !clr, "R2 reset pulses", {tpa, tpb, din, clr}, 0);
    release_and_time("R1 init length");

    // R3 / R1 pulse placement and cycle length
    to_fetch();
    n = 0;
    do begin @(negedge clk); n++; end while (!tpb && n < 20);
    chk(n == 5, "R3 tpa to tpb", n, 5);
    m = n;
    do begin @(negedge clk); m++; end while (!tpa && m < 20);
    chk(m == 8, "R1 cycle length", m, 8);

    // vector table: R4 R5 R6 R10 R12
    for (int i = 0; i < 9; i++) begin
      v = VEC[i];
      to_fetch();
      next_tpa();
      chk(code == 2'b01, "R4 exec after fetch", code, 1);
      {dmai, dmao, irq, ien, lng} = v[9:5];
      next_tpa();
      chk(code == v[4:3], "R5/R6 vector next", code, v[4:3]);
      chk(din == v[2], "R12 vector dma dir", din, v[2]);
      if (v[4:3] == 2'b11) chk(clr == 1'b1, "R10 clear strobe", clr, 1);
      clear_in();
      next_tpa();
      chk(code == v[1:0], "R5/R6 vector after", code, v[1:0]);
    end

    // R8 chaining
    to_fetch();
    next_tpa();
    dmai = 1;
    next_tpa();
    chk(code == 2'b10, "R5 dma after exec", code, 2);
    next_tpa();
    chk(code == 2'b10, "R8 dma after dma", code, 2);
    dmai = 0; irq = 1; ien = 1;
    next_tpa();
    chk(code == 2'b11, "R8 int after dma", code, 3);
    chk(clr == 1'b1, "R10 clear in int", clr, 1);
    ien = 0; irq = 0; dmao = 1;
    next_tpa();
    chk(code == 2'b10, "R8 dma after int", code, 2);
    chk(din == 1'b0, "R12 outbound dir", din, 0);
    dmao = 0;
    next_tpa();
    chk(code == 2'b00, "R5 fetch after chain", code, 0);

    // R7 idle
    to_fetch();
    next_tpa();
    idl = 1;
    next_tpa();
    chk(code == 2'b01, "R7 idle exec 1", code, 1);
    idl = 0;
    next_tpa();
    chk(code == 2'b01, "R7 idle exec 2", code, 1);
    next_tpa();
    chk(code == 2'b01, "R7 idle exec 3", code, 1);
    dmao = 1;
    next_tpa();
    chk(code == 2'b10, "R7 idle exit dma", code, 2);
    dmao = 0;
    next_tpa();
    chk(code == 2'b00, "R7 normal after idle", code, 0);

    // R9 pause
    to_fetch();
    hold = 1;
    c0 = code;
    ok = 1;
    repeat (20) begin
      @(negedge clk);
      if (!tpa || tpb || code != c0) ok = 0;
    end
    chk(ok, "R9 frozen outputs", {tpa, tpb, code}, {2'b10, c0});
    hold = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!tpb && n < 20);
    chk(n == 5, "R9 resume phase", n, 5);
    next_tpa();
    chk(code == 2'b01, "R9 sequence kept", code, 1);

    // R11 early-dropped request
    to_fetch();
    next_tpa();
    dmai = 1;
    @(negedge clk);
    @(negedge clk);
    dmai = 0;
    next_tpa();
    chk(code == 2'b00, "R11 dropped dma", code, 0);

    // R13 mid-cycle reset
    to_fetch();
    next_tpa();
    rst_n = 0;
    #1;
    chk(code == 2'b01, "R13 reset code", code, 1);
    chk(!tpa && !tpb, "R13 reset pulses", {tpa, tpb}, 0);
    release_and_time("R13 init after reset");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule